// File: doc/BRIEF.md
# Bit-Parallel Stuck-At Fault Gate Evaluator

This datapath evaluates one logic gate across W copies of a circuit in a single cycle. It serves as the inner step of a hardware fault simulator. Every signal is carried as two W-bit plane words, and each bit lane holds one circuit copy. Lane 0 is always the fault-free circuit. Every other lane is a copy that carries one single stuck-at fault, chosen by the caller. Values are three-valued: 0, 1 or unknown.

For each gate evaluation, the caller supplies the two operand signals, the gate type, and an insert mask and a stuck-value mask for each input line and for the output line. The block injects faults on the inputs, evaluates the gate in every lane, and injects faults on the output. It then registers the result. When the output is a primary output, it also flags the faulty lanes whose binary value disagrees with the good lane.

Each lane has a saturating detection counter. Once a lane has been detected k times, that lane is marked dropped, and its insert-mask bits are ignored from then on. A new pass, started with a single pulse, clears all counters and drop marks so that a new fault-to-lane assignment can begin. A set of F faults therefore takes ceil(F/(W-1)) passes.

Top module: `fault_lane_eval`

## Requirements
- R1: A lane value is coded on two planes (p1,p2): 0 is (0,0), 1 is (1,1) and unknown is (0,1). When the operands carry no (1,0) code, the output never carries it. Lane 0 (bit 0) is the good circuit and never receives a fault, whatever its mask bits are.
- R2: `op_i` = 0 gives AND and `op_i` = 1 gives OR. Both are computed planewise. A 0 dominates AND, a 1 dominates OR, and otherwise any unknown operand gives unknown.
- R3: `op_i` = 2 gives NOT of operand A, `op_i` = 3 gives NAND and `op_i` = 4 gives NOR. Inversion maps 0 to 1, 1 to 0, and unknown to unknown.
- R4: In each faulty lane whose insert bit is set, an input line takes the stuck value before the gate is evaluated. The stuck value is `sa_i`/`sb_i`, which sets both planes.
- R5: After evaluation, in each faulty lane whose `iz_i` bit is set, the output takes the `sz_i` value.
- R6: The result appears one cycle after `in_valid_i`, and `out_valid_o` follows `in_valid_i` one cycle later. `z1_o`/`z2_o` hold their value while no evaluation is valid. All outputs are 0 after reset.
- R7: `det_o[j]` is 1 one cycle after a valid evaluation with `is_po_i` = 1, when lane j ≠ 0 and both lane j and lane 0 are binary and their values differ. An unknown in either lane never counts as a detection. In every other case `det_o` is 0.
- R8: Each detection adds one to that lane's counter, which saturates at its maximum value. A detection that leaves the count at or above `k_thresh_i` sets `drop_o` for that lane. When `k_thresh_i` = 0, no lane is ever dropped. A set drop flag stays set until a new pass starts.
- R9: In a lane whose `drop_o` bit is set, all three insert masks are ignored, so that lane computes the fault-free function.
- R10: `pass_start_i` clears all counters and drop flags. An evaluation in the same cycle uses every mask as given, and any detection it makes is counted from zero.
- R11: Codes 5 to 7 of `op_i` produce unknown in every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pass_start_i | input | 1 | Start of a new pass; clears counters and drop flags |
| k_thresh_i | input | CNT_W | Detection count at which a lane is dropped (0 = never) |
| in_valid_i | input | 1 | An evaluation is presented this cycle |
| op_i | input | 3 | Gate type code |
| is_po_i | input | 1 | The gate output is a primary output |
| a1_i | input | W | Operand A, plane 1 |
| a2_i | input | W | Operand A, plane 2 |
| b1_i | input | W | Operand B, plane 1 |
| b2_i | input | W | Operand B, plane 2 |
| ia_i | input | W | Insert mask for line A |
| sa_i | input | W | Stuck values for line A |
| ib_i | input | W | Insert mask for line B |
| sb_i | input | W | Stuck values for line B |
| iz_i | input | W | Insert mask for the output line |
| sz_i | input | W | Stuck values for the output line |
| out_valid_o | output | 1 | Registered result is valid |
| z1_o | output | W | Output, plane 1 |
| z2_o | output | W | Output, plane 2 |
| det_o | output | W | Per-lane detection flags for the last evaluation |
| drop_o | output | W | Per-lane dropped flags |

## Verification
Two functions can act in the same cycle. The first is the pass-start clear. The second is counting a detection from a primary-output evaluation, which in the same cycle may push a lane to its threshold and drop it. The bench provokes this by asserting `pass_start_i` during a valid primary-output evaluation with a threshold of 1. It expects each detecting lane to count from zero and drop at once, while lanes dropped in the earlier pass are released and receive their faults again. A behavioural per-lane model predicts the outputs, detections and drop flags and is compared with them on every clock.

// File: rtl/fle_pkg.sv
package fle_pkg;
  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_NOT  = 3'd2,
    OP_NAND = 3'd3,
    OP_NOR  = 3'd4
  } gate_op_e;
endpackage

// File: rtl/fle_inject.sv
// Applies stuck-at insertion to a two-plane signal: both planes take the stuck value.
module fle_inject #(
  parameter int W = 16
) (
  input  logic [W-1:0] v1_i,
  input  logic [W-1:0] v2_i,
  input  logic [W-1:0] ins_i,
  input  logic [W-1:0] stk_i,
  output logic [W-1:0] v1_o,
  output logic [W-1:0] v2_o
);
  assign v1_o = (v1_i & ~ins_i) | (ins_i & stk_i);
  assign v2_o = (v2_i & ~ins_i) | (ins_i & stk_i);
endmodule

// File: rtl/fle_gate.sv
module fle_gate #(
  parameter int W = 16
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a1_i,
  input  logic [W-1:0] a2_i,
  input  logic [W-1:0] b1_i,
  input  logic [W-1:0] b2_i,
  output logic [W-1:0] z1_o,
  output logic [W-1:0] z2_o
);
  import fle_pkg::*;

  logic [W-1:0] and1, and2, or1, or2;

  assign and1 = a1_i & b1_i;
  assign and2 = a2_i & b2_i;
  assign or1  = a1_i | b1_i;
  assign or2  = a2_i | b2_i;

  // inversion swaps and complements planes so unknown stays unknown
  always_comb begin
    case (gate_op_e'(op_i))
      OP_AND:  begin z1_o = and1; z2_o = and2; end
      OP_OR:   begin z1_o = or1;  z2_o = or2;  end
      OP_NOT:  begin z1_o = ~a2_i; z2_o = ~a1_i; end
      OP_NAND: begin z1_o = ~and2; z2_o = ~and1; end
      OP_NOR:  begin z1_o = ~or2;  z2_o = ~or1;  end
      default: begin z1_o = '0;   z2_o = '1;   end
    endcase
  end
endmodule

// File: rtl/fle_detect.sv
module fle_detect #(
  parameter int W = 16
) (
  input  logic         en_i,
  input  logic [W-1:0] z1_i,
  input  logic [W-1:0] z2_i,
  output logic [W-1:0] hit_o
);
  localparam logic [W-1:0] FAULTY_LANES = ~W'(1);

  logic         good_bin;
  logic [W-1:0] lane_bin, good_rep;

  assign good_bin = (z1_i[0] == z2_i[0]);
  assign good_rep = {W{z1_i[0]}};
  assign lane_bin = ~(z1_i ^ z2_i);
  assign hit_o    = (en_i && good_bin) ? (lane_bin & (z1_i ^ good_rep) & FAULTY_LANES) : '0;
endmodule

// File: rtl/fle_lane_cnt.sv
module fle_lane_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             hit_i,
  input  logic [CNT_W-1:0] k_i,
  output logic             drop_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_base, cnt_nxt;
  logic             drop_q, drop_base, drop_nxt;

  assign cnt_base  = clr_i ? '0 : cnt_q;
  assign drop_base = clr_i ? 1'b0 : drop_q;
  assign cnt_nxt   = (hit_i && cnt_base != CNT_MAX) ? cnt_base + 1'b1 : cnt_base;
  assign drop_nxt  = drop_base | (hit_i && k_i != '0 && cnt_nxt >= k_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      drop_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      drop_q <= drop_nxt;
    end
  end

  assign drop_o = drop_q;
endmodule

// File: rtl/fault_lane_eval.sv
module fault_lane_eval #(
  parameter int W     = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pass_start_i,
  input  logic [CNT_W-1:0] k_thresh_i,
  input  logic             in_valid_i,
  input  logic [2:0]       op_i,
  input  logic             is_po_i,
  input  logic [W-1:0]     a1_i,
  input  logic [W-1:0]     a2_i,
  input  logic [W-1:0]     b1_i,
  input  logic [W-1:0]     b2_i,
  input  logic [W-1:0]     ia_i,
  input  logic [W-1:0]     sa_i,
  input  logic [W-1:0]     ib_i,
  input  logic [W-1:0]     sb_i,
  input  logic [W-1:0]     iz_i,
  input  logic [W-1:0]     sz_i,
  output logic             out_valid_o,
  output logic [W-1:0]     z1_o,
  output logic [W-1:0]     z2_o,
  output logic [W-1:0]     det_o,
  output logic [W-1:0]     drop_o
);
  localparam logic [W-1:0] FAULTY_LANES = ~W'(1);

  logic [W-1:0] drop_q, lane_en;
  logic [W-1:0] fa1, fa2, fb1, fb2, g1, g2, fz1, fz2, hit;
  logic         det_en;

  // a new pass releases dropped lanes for the evaluation in the same cycle
  assign lane_en = (pass_start_i ? '1 : ~drop_q) & FAULTY_LANES;
  assign det_en  = in_valid_i & is_po_i;

  fle_inject #(.W(W)) u_inj_a (
    .v1_i(a1_i), .v2_i(a2_i), .ins_i(ia_i & lane_en), .stk_i(sa_i),
    .v1_o(fa1),  .v2_o(fa2)
  );

  fle_inject #(.W(W)) u_inj_b (
    .v1_i(b1_i), .v2_i(b2_i), .ins_i(ib_i & lane_en), .stk_i(sb_i),
    .v1_o(fb1),  .v2_o(fb2)
  );

  fle_gate #(.W(W)) u_gate (
    .op_i(op_i), .a1_i(fa1), .a2_i(fa2), .b1_i(fb1), .b2_i(fb2),
    .z1_o(g1),   .z2_o(g2)
  );

  fle_inject #(.W(W)) u_inj_z (
    .v1_i(g1), .v2_i(g2), .ins_i(iz_i & lane_en), .stk_i(sz_i),
    .v1_o(fz1), .v2_o(fz2)
  );

  fle_detect #(.W(W)) u_det (
    .en_i(det_en), .z1_i(fz1), .z2_i(fz2), .hit_o(hit)
  );

  for (genvar g = 0; g < W; g++) begin : g_lane
    if (g == 0) begin : g_good
      assign drop_q[g] = 1'b0;
    end else begin : g_faulty
      fle_lane_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .clr_i (pass_start_i),
        .hit_i (hit[g]),
        .k_i   (k_thresh_i),
        .drop_o(drop_q[g])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      z1_o        <= '0;
      z2_o        <= '0;
      det_o       <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      det_o       <= hit;
      if (in_valid_i) begin
        z1_o <= fz1;
        z2_o <= fz2;
      end
    end
  end

  assign drop_o = drop_q;
endmodule

// File: rtl/fle_checker.sv
module fle_checker #(
  parameter int W     = 16,
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pass_start_i,
  input logic [CNT_W-1:0] k_thresh_i,
  input logic             in_valid_i,
  input logic [2:0]       op_i,
  input logic             is_po_i,
  input logic [W-1:0]     a1_i,
  input logic [W-1:0]     a2_i,
  input logic [W-1:0]     b1_i,
  input logic [W-1:0]     b2_i,
  input logic [W-1:0]     ia_i,
  input logic [W-1:0]     sa_i,
  input logic [W-1:0]     ib_i,
  input logic [W-1:0]     sb_i,
  input logic [W-1:0]     iz_i,
  input logic [W-1:0]     sz_i,
  input logic             out_valid_o,
  input logic [W-1:0]     z1_o,
  input logic [W-1:0]     z2_o,
  input logic [W-1:0]     det_o,
  input logic [W-1:0]     drop_o
);
  localparam logic [W-1:0] FAULTY_LANES = ~W'(1);

  AST_NO_ILLEGAL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && ((a1_i & ~a2_i) | (b1_i & ~b2_i)) == '0) |=> ((z1_o & ~z2_o) == '0)); // R1

  AST_GOOD_LANE_NEVER_DET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_o[0] == 1'b0); // R7

  AST_DET_NEEDS_PO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && is_po_i) |=> (det_o == '0)); // R7

  AST_DROP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pass_start_i |=> (($past(drop_o) & ~drop_o) == '0)); // R8

  AST_PASS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_start_i && !(in_valid_i && is_po_i)) |=> (drop_o == '0)); // R10

  AST_OUT_STUCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !pass_start_i) |=>
      ((((z1_o ^ $past(sz_i)) | (z2_o ^ $past(sz_i))) & $past(iz_i & ~drop_o) & FAULTY_LANES) == '0)); // R5

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(z1_o) && $stable(z2_o) && !out_valid_o)); // R6
endmodule

bind fault_lane_eval fle_checker #(.W(W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/fault_lane_eval_tb.sv
`timescale 1ns/1ps
module fault_lane_eval_tb;
  localparam int W       = 16;
  localparam int CNT_W   = 8;
  localparam int CNT_MAX = 255;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             pass_start = 1'b0;
  logic [CNT_W-1:0] k_thresh = '0;
  logic             in_valid = 1'b0;
  logic [2:0]       op = '0;
  logic             is_po = 1'b0;
  logic [W-1:0]     a1 = '0, a2 = '0, b1 = '0, b2 = '0;
  logic [W-1:0]     ia = '0, sa = '0, ib = '0, sb = '0, iz = '0, sz = '0;
  logic             out_valid;
  logic [W-1:0]     z1, z2, det, drop;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // model state
  int           m_cnt [W];
  bit           m_drop [W];
  logic [W-1:0] e_z1 = '0, e_z2 = '0, e_det = '0, e_drop = '0;
  logic         e_valid = 1'b0;

  always #10 clk = ~clk;

  fault_lane_eval #(.W(W), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pass_start_i(pass_start), .k_thresh_i(k_thresh),
    .in_valid_i(in_valid), .op_i(op), .is_po_i(is_po),
    .a1_i(a1), .a2_i(a2), .b1_i(b1), .b2_i(b2),
    .ia_i(ia), .sa_i(sa), .ib_i(ib), .sb_i(sb), .iz_i(iz), .sz_i(sz),
    .out_valid_o(out_valid), .z1_o(z1), .z2_o(z2), .det_o(det), .drop_o(drop)
  );

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int dec(bit p1, bit p2);
    return p1 ? 1 : (p2 ? 2 : 0);
  endfunction

  function automatic int v_and(int a, int b);
    if (a == 0 || b == 0) return 0;
    if (a == 1 && b == 1) return 1;
    return 2;
  endfunction

  function automatic int v_or(int a, int b);
    if (a == 1 || b == 1) return 1;
    if (a == 0 && b == 0) return 0;
    return 2;
  endfunction

  function automatic int v_not(int a);
    return (a == 2) ? 2 : 1 - a;
  endfunction

  // one evaluation cycle: predict, clock, compare, commit
  task automatic step(string zreq);
    int zv [W];
    logic [W-1:0] n_z1, n_z2, n_det;
    for (int j = 0; j < W; j++) begin
      bit en;
      int av, bv, r;
      en = (j != 0) && (pass_start || !m_drop[j]);
      av = dec(a1[j], a2[j]);
      bv = dec(b1[j], b2[j]);
      if (en && ia[j]) av = sa[j];
      if (en && ib[j]) bv = sb[j];
      case (op)
        3'd0: r = v_and(av, bv);
        3'd1: r = v_or(av, bv);
        3'd2: r = v_not(av);
        3'd3: r = v_not(v_and(av, bv));
        3'd4: r = v_not(v_or(av, bv));
        default: r = 2;
      endcase
      if (en && iz[j]) r = sz[j];
      zv[j]   = r;
      n_z1[j] = (r == 1);
      n_z2[j] = (r != 0);
    end
    for (int j = 0; j < W; j++)
      n_det[j] = in_valid && is_po && j != 0 && zv[0] != 2 && zv[j] != 2 && zv[j] != zv[0];
    for (int j = 1; j < W; j++) begin
      if (pass_start) begin
        m_cnt[j]  = 0;
        m_drop[j] = 0;
      end
      if (n_det[j]) begin
        if (m_cnt[j] < CNT_MAX) m_cnt[j]++;
        if (k_thresh != 0 && m_cnt[j] >= int'(k_thresh)) m_drop[j] = 1;
      end
      e_drop[j] = m_drop[j];
    end
    e_drop[0] = 1'b0;
    if (in_valid) begin
      e_z1 = n_z1;
      e_z2 = n_z2;
    end
    e_det   = n_det;
    e_valid = in_valid;
    @(posedge clk);
    @(negedge clk);
    if (!done) begin
      chk(zreq, z1, e_z1);
      chk(zreq, z2, e_z2);
      chk("R7", det, e_det);
      chk("R8", drop, e_drop);
      chk("R6", W'(out_valid), W'(e_valid));
    end
  endtask

  task automatic rand_operands();
    for (int j = 0; j < W; j++) begin
      int v;
      v = $urandom % 3;
      a1[j] = (v == 1); a2[j] = (v != 0);
      v = $urandom % 3;
      b1[j] = (v == 1); b2[j] = (v != 0);
    end
  endtask

  task automatic run(string zreq, int n, int op_lo, int op_hi, bit in_m, bit out_m, bit po);
    for (int i = 0; i < n; i++) begin
      rand_operands();
      op       = 3'(op_lo + ($urandom % (op_hi - op_lo + 1)));
      in_valid = ($urandom % 5) != 0;
      is_po    = po;
      ia = in_m  ? W'($urandom & $urandom) : '0;
      ib = in_m  ? W'($urandom & $urandom) : '0;
      iz = out_m ? W'($urandom & $urandom) : '0;
      sa = W'($urandom); sb = W'($urandom); sz = W'($urandom);
      step(zreq);
    end
  endtask

  initial begin
    for (int j = 0; j < W; j++) begin m_cnt[j] = 0; m_drop[j] = 0; end
    repeat (3) @(negedge clk);
    chk("R6", W'(out_valid), '0);
    chk("R6", z1, '0);
    chk("R7", det, '0);
    chk("R8", drop, '0);
    rst_n = 1'b1;
    @(negedge clk);

    run("R2", 60, 0, 1, 0, 0, 0);
    run("R3", 60, 2, 4, 0, 0, 0);
    run("R11", 20, 5, 7, 0, 0, 0);
    run("R4", 60, 0, 4, 1, 0, 0);
    run("R5", 60, 0, 4, 0, 1, 0);

    // R1: all masks set, good lane must stay fault free
    in_valid = 1'b1; op = 3'd1; is_po = 1'b0;
    a1 = '0; a2 = '0; b1 = '0; b2 = '0;
    ia = '1; sa = '1; ib = '1; sb = '1; iz = '0; sz = '0;
    step("R1");
    chk("R1", W'(z1[0]), '0);
    chk("R1", z1 & ~W'(1), ~W'(1));

    // R7: detections with no dropping
    k_thresh = '0;
    run("R7", 80, 0, 4, 1, 1, 1);

    // R8: threshold 2 in a fresh pass
    pass_start = 1'b1; k_thresh = 8'd2; in_valid = 1'b0;
    step("R10");
    pass_start = 1'b0;
    run("R8", 80, 0, 4, 1, 1, 1);

    // R9: every mask on; dropped lanes must compute the good function
    for (int i = 0; i < 30; i++) begin
      rand_operands();
      op = 3'($urandom % 5); in_valid = 1'b1; is_po = 1'b1;
      ia = '1; ib = '1; iz = '1;
      sa = W'($urandom); sb = W'($urandom); sz = W'($urandom);
      step("R9");
    end

    // R10: pass start together with a detecting evaluation, k = 1
    k_thresh = 8'd1;
    in_valid = 1'b1; is_po = 1'b1; op = 3'd0;
    a1 = '1; a2 = '1; b1 = '1; b2 = '1;
    ia = '0; ib = '0; iz = W'(16'h00F0); sz = '0;
    pass_start = 1'b1;
    step("R10");
    pass_start = 1'b0;
    chk("R10", det, W'(16'h00F0));
    chk("R10", drop, W'(16'h00F0));
    run("R10", 40, 0, 4, 1, 1, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule